// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Control

This block decides where each operand of a five-stage integer pipeline comes from. For the two operands of the instruction in the execute stage, it checks the source register ids against the destination ids held in the two later pipeline registers. It then drives the bypass-mux selects so that the newest pending result replaces the stale register-file value.

For the instruction in the decode stage, the block makes two decisions. It flags a register-file read that coincides with a write-back to the same register, so the value being written passes straight to the read port. It also detects a load in execute whose destination the decode instruction reads. In that case it freezes the program counter and the fetch/decode register for one cycle and injects an empty slot into execute.

The block is purely combinational. It takes register ids, write enables and a memory-read flag from the surrounding pipeline registers. Its outputs feed the datapath muxes and the enable and clear pins of those registers.

Top module: `hazard_ctl`

## Requirements
- R1: An execute operand whose id is nonzero and equal to the execute/memory destination id, with that stage's write enable set, gets select 2'b10.
- R2: An execute operand that matches only the memory/write-back destination (nonzero id, write enable set) gets select 2'b01.
- R3: When both later stages match an execute operand, the select is 2'b10, because the execute/memory result is the newer one.
- R4: An operand with no qualifying match gets select 2'b00 (register file). This covers a producer whose write enable is low, and any id of 0. The value 2'b11 never appears.
- R5: Operand A (select `fwd_a`, id `ex_rs1`) and operand B (select `fwd_b`, id `ex_rs2`) are resolved independently, each under R1 to R4.
- R6: When execute holds a load (memory-read and write enable both set, destination nonzero) whose destination equals either decode source id, `pc_hold`, `ifid_hold` and `bubble` are all 1.
- R7: No stall is raised for a matching instruction in execute that is not a load, for a load to register 0, or for a load whose destination neither decode source uses.
- R8: `wt_a` (`wt_b`) is 1 when the write-back stage writes a nonzero register equal to decode source 1 (2).
- R9: Write-through never flags register 0 and never flags anything while the write-back enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | RW | decode-stage source id 1 |
| id_rs2 | input | RW | decode-stage source id 2 |
| ex_rs1 | input | RW | execute-stage source id for operand A |
| ex_rs2 | input | RW | execute-stage source id for operand B |
| ex_rd | input | RW | execute-stage destination id |
| ex_we | input | 1 | execute-stage register write enable |
| ex_memrd | input | 1 | execute-stage instruction is a load |
| exm_rd | input | RW | execute/memory register destination id |
| exm_we | input | 1 | execute/memory register write enable |
| mwb_rd | input | RW | memory/write-back register destination id |
| mwb_we | input | 1 | memory/write-back register write enable |
| fwd_a | output | 2 | operand A select: 00 file, 10 exe/mem, 01 mem/wb |
| fwd_b | output | 2 | operand B select, same encoding |
| wt_a | output | 1 | decode read 1 takes the write-back data |
| wt_b | output | 1 | decode read 2 takes the write-back data |
| pc_hold | output | 1 | hold the program counter |
| ifid_hold | output | 1 | hold the fetch/decode register |
| bubble | output | 1 | clear control bits entering execute |

## Verification
The block keeps no state, so a wrong comparison shows at the ports in the same evaluation that presents the ids. A dropped priority appears as 2'b01 where 2'b10 belongs. A missing zero-register guard shows as a select, write-through flag or stall raised for id 0. A stall qualified on the wrong stage either freezes fetch on a plain ALU match or lets a load-use pair through. The cycle-by-cycle load-use sequence confirms that the stall lasts exactly one cycle: once the bubble has entered execute, the consumer resolves through the 2'b01 path.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic [RW-1:0] ex_rs1,
  input  logic [RW-1:0] ex_rs2,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_memrd,
  input  logic [RW-1:0] exm_rd,
  input  logic          exm_we,
  input  logic [RW-1:0] mwb_rd,
  input  logic          mwb_we,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          wt_a,
  output logic          wt_b,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          bubble
);
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_EXM = 2'b10;
  localparam logic [1:0] SEL_MWB = 2'b01;
  localparam logic [RW-1:0] R0 = '0;

  function automatic logic hit(input logic we, input logic [RW-1:0] rd,
                               input logic [RW-1:0] rs);
    return we && (rd != R0) && (rd == rs);
  endfunction

  function automatic logic [1:0] pick(input logic [RW-1:0] rs);
    if (hit(exm_we, exm_rd, rs))      return SEL_EXM;
    else if (hit(mwb_we, mwb_rd, rs)) return SEL_MWB;
    else                              return SEL_RF;
  endfunction

  logic load_ex, stall;

  assign fwd_a = pick(ex_rs1);
  assign fwd_b = pick(ex_rs2);

  assign wt_a = hit(mwb_we, mwb_rd, id_rs1);
  assign wt_b = hit(mwb_we, mwb_rd, id_rs2);

  assign load_ex   = ex_memrd && ex_we;
  assign stall     = hit(load_ex, ex_rd, id_rs1) || hit(load_ex, ex_rd, id_rs2);
  assign pc_hold   = stall;
  assign ifid_hold = stall;
  assign bubble    = stall;

  always_comb begin
    if (fwd_a == SEL_EXM)
      a_r1_exm_src: assert (exm_we && exm_rd == ex_rs1 && ex_rs1 != R0);
    if (fwd_b == SEL_MWB)
      a_r2_mwb_src: assert (mwb_we && mwb_rd == ex_rs2 && !(exm_we && exm_rd == ex_rs2));
    if (exm_we && ex_rs1 != R0 && exm_rd == ex_rs1)
      a_r3_newest_wins: assert (fwd_a == SEL_EXM);
    a_r4_legal_sel: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
    if (bubble)
      a_r6_load_only: assert (ex_memrd && ex_we && ex_rd != R0 && pc_hold && ifid_hold);
    if (wt_a)
      a_r9_no_zero_wt: assert (mwb_we && id_rs1 != R0);
  end
endmodule

// File: tb/sim_hazard_ctl.sv
module sim_hazard_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;
  localparam int NV = 15;

  logic clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [RW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, exm_rd, mwb_rd;
  logic ex_we, ex_memrd, exm_we, mwb_we;
  logic [1:0] fwd_a, fwd_b;
  logic wt_a, wt_b, pc_hold, ifid_hold, bubble;

  hazard_ctl #(.RW(RW)) u0 (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_memrd(ex_memrd),
    .exm_rd(exm_rd), .exm_we(exm_we), .mwb_rd(mwb_rd), .mwb_we(mwb_we),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .wt_a(wt_a), .wt_b(wt_b),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .bubble(bubble));

  // {req, id_rs1,id_rs2,ex_rs1,ex_rs2,ex_rd,exm_rd,mwb_rd, ex_we,ex_memrd,exm_we,mwb_we,
  //  fa,fb,wa,wb,stall}
  localparam logic [49:0] VEC [NV] = '{
    {4'd4, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 4'b0000, 2'b00,2'b00,3'b000}, // R4 idle
    {4'd1, 5'd0, 5'd0, 5'd3, 5'd0, 5'd0, 5'd3, 5'd0, 4'b0010, 2'b10,2'b00,3'b000}, // R1
    {4'd2, 5'd0, 5'd0, 5'd0, 5'd7, 5'd0, 5'd0, 5'd7, 4'b0001, 2'b00,2'b01,3'b000}, // R2
    {4'd3, 5'd0, 5'd0, 5'd4, 5'd4, 5'd0, 5'd4, 5'd4, 4'b0011, 2'b10,2'b10,3'b000}, // R3
    {4'd4, 5'd0, 5'd0, 5'd5, 5'd0, 5'd0, 5'd5, 5'd0, 4'b0000, 2'b00,2'b00,3'b000}, // R4 we low
    {4'd4, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 4'b0011, 2'b00,2'b00,3'b000}, // R4 reg0
    {4'd5, 5'd0, 5'd0, 5'd6, 5'd9, 5'd0, 5'd9, 5'd6, 4'b0011, 2'b01,2'b10,3'b000}, // R5
    {4'd6, 5'd8, 5'd0, 5'd0, 5'd0, 5'd8, 5'd0, 5'd0, 4'b1100, 2'b00,2'b00,3'b001}, // R6 rs1
    {4'd6, 5'd0, 5'd8, 5'd0, 5'd0, 5'd8, 5'd0, 5'd0, 4'b1100, 2'b00,2'b00,3'b001}, // R6 rs2
    {4'd7, 5'd8, 5'd0, 5'd0, 5'd0, 5'd8, 5'd0, 5'd0, 4'b1000, 2'b00,2'b00,3'b000}, // R7 alu
    {4'd7, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 4'b1100, 2'b00,2'b00,3'b000}, // R7 reg0
    {4'd8, 5'd10,5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd10,4'b0001, 2'b00,2'b00,3'b100}, // R8 a
    {4'd8, 5'd0, 5'd11,5'd0, 5'd0, 5'd0, 5'd0, 5'd11,4'b0001, 2'b00,2'b00,3'b010}, // R8 b
    {4'd9, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 4'b0001, 2'b00,2'b00,3'b000}, // R9 reg0
    {4'd9, 5'd12,5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd12,4'b0000, 2'b00,2'b00,3'b000}  // R9 we low
  };

  int nchk = 0, nbad = 0;
  bit done = 0;

  task automatic drive(input logic [44:0] v);
    {id_rs1,id_rs2,ex_rs1,ex_rs2,ex_rd,exm_rd,mwb_rd,ex_we,ex_memrd,exm_we,mwb_we} = {v[44:7]};
  endtask

  task automatic check(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {fwd_a, fwd_b, wt_a, wt_b, bubble};
    nchk++;
    if (act !== exp || pc_hold !== bubble || ifid_hold !== bubble) begin
      nbad++;
      $display("FAIL %s: got %b (hold %b%b) expected %b", req, act, pc_hold, ifid_hold, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    if (!done) begin
      nbad++; nchk++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    {id_rs1,id_rs2,ex_rs1,ex_rs2,ex_rd,exm_rd,mwb_rd,ex_we,ex_memrd,exm_we,mwb_we} = '0;
    @(negedge clk);
    check("R4 reset", 7'b0);
    for (int i = 0; i < NV; i++) begin
      {id_rs1,id_rs2,ex_rs1,ex_rs2,ex_rd,exm_rd,mwb_rd,ex_we,ex_memrd,exm_we,mwb_we} = VEC[i][45:7];
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i][49:46], i), VEC[i][6:0]);
    end
    // R6 sequence: load r9 in EX, consumer reads r9 in ID -> one stall
    {id_rs1,id_rs2,ex_rs1,ex_rs2,ex_rd,exm_rd,mwb_rd,ex_we,ex_memrd,exm_we,mwb_we} = '0;
    ex_rd = 5'd9; ex_we = 1; ex_memrd = 1; id_rs1 = 5'd9; id_rs2 = 5'd2;
    @(negedge clk);
    check("R6 seq stall", 7'b0000001);
    // bubble in EX, load in EXM, consumer still in ID: no stall (R7)
    ex_rd = 5'd0; ex_we = 0; ex_memrd = 0; exm_rd = 5'd9; exm_we = 1;
    @(negedge clk);
    check("R7 seq release", 7'b0000000);
    // consumer in EX, load in MWB: operand A from MEM/WB (R2)
    ex_rs1 = 5'd9; ex_rs2 = 5'd2; exm_rd = 5'd0; exm_we = 0; mwb_rd = 5'd9; mwb_we = 1;
    id_rs1 = 5'd0; id_rs2 = 5'd0;
    @(negedge clk);
    check("R2 seq resolve", 7'b0100000);
    // R9 write-through of reg 0 while ID reads reg 0 on both ports
    {id_rs1,id_rs2,ex_rs1,ex_rs2,ex_rd,exm_rd,mwb_rd,ex_we,ex_memrd,exm_we,mwb_we} = '0;
    mwb_we = 1;
    @(negedge clk);
    check("R9 reg0 both", 7'b0000000);
    // R8 both ports read the same written register
    id_rs1 = 5'd31; id_rs2 = 5'd31; mwb_rd = 5'd31;
    @(negedge clk);
    check("R8 both ports", 7'b0000110);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule